// File: doc/BRIEF.md
# Per-Line Panel Strobe Generator

This block places the per-line control strobes of a TFT panel that is fed through a synchronous pixel interface. There are four strobes: a one-clock start pulse, a clock-select strobe, a power-select strobe and a line-polarity reversal signal. Each edge of each strobe has its own delay register, counted in whole pixel clocks from the line reference point. The line reference point is the rising clock edge at which `line_start` is sampled high.

All delay inputs are captured when a line starts. A write made in the middle of a line therefore takes effect only from the next line. A new `line_start` restarts the count at once, and any edge of the old line that has not yet occurred is dropped. If no line starts, the position counter saturates and the strobes hold their levels.

Top module: `lstr_strobe_gen`

## Requirements
- R1: During reset and after it the outputs are `start_pulse`=0, `clk_sel`=0, `pwr_sel`=1, `rev_out`=0. No output changes until the first `line_start` is sampled high, whatever the delay inputs are.
- R2: For a start delay B, `start_pulse` is high for exactly one clock. It turns high at the (B−1)-th rising edge after the reference edge. When B is 0 or 1 it turns high at the reference edge itself.
- R3: `clk_sel` goes high at the N-th rising edge after the reference edge, where N is `dly_cls_on` (N=0 means the reference edge).
- R4: `clk_sel` goes low at the `dly_cls_off`-th edge after the reference edge. When both clock-select delays are equal, `clk_sel` ends up high.
- R5: `pwr_sel` goes low at the `dly_ps_off`-th edge and high at the `dly_ps_on`-th edge after the reference edge. When the two are equal, `pwr_sel` ends up low.
- R6: `rev_out` inverts exactly once per line, at the `dly_rev`-th edge after the reference edge, and at no other time.
- R7: The delay inputs are used only as sampled on the reference edge. A change during a line has no effect on that line's outputs and applies from the next `line_start`.
- R8: A `line_start` restarts the count from zero, including one that arrives on consecutive cycles. An edge of the previous line that has not occurred by then never occurs. Levels carry over from the previous line until the new line's edges move them. An edge whose delay lies beyond 2^8−1 never occurs, so no edge repeats on a long line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Line reference strobe, sampled on the rising edge |
| dly_start | input | 8 | Start pulse delay B (pulse at B−1, floored at 0) |
| dly_cls_on | input | 8 | Clock-select rising edge delay |
| dly_cls_off | input | 8 | Clock-select falling edge delay |
| dly_ps_off | input | 8 | Power-select falling edge delay |
| dly_ps_on | input | 8 | Power-select rising edge delay |
| dly_rev | input | 8 | Reversal toggle delay |
| start_pulse | output | 1 | One-clock start pulse |
| clk_sel | output | 1 | Clock-select strobe, idle low |
| pwr_sel | output | 1 | Power-select strobe, idle high |
| rev_out | output | 1 | Line polarity reversal |

## Verification
The bench builds the block with the package default of 8-bit delays, so the counter saturates at 256. Random lines run up to 90 clocks with delays up to 99. This makes lines that end before some of their edges occur as common as lines that complete, and it reaches the carry-over of levels across restarts. One directed line of 300 clocks passes the saturation point and shows that no edge repeats. Start delays of 0 and 1, equal on/off delays, back-to-back line starts and mid-line delay changes are each driven on purpose.

// File: rtl/lstr_pkg.sv
package lstr_pkg;

    localparam int LSTR_DW = 8;

    typedef logic [LSTR_DW-1:0] dly_t;

    typedef struct packed {
        dly_t start;
        dly_t cls_on;
        dly_t cls_off;
        dly_t ps_off;
        dly_t ps_on;
        dly_t rev;
    } dly_set_t;

    typedef enum logic [1:0] {
        CELL_PULSE,
        CELL_LEVEL,
        CELL_TOGGLE
    } cell_mode_e;

    // start pulse position: one before the programmed value, floored at zero
    function automatic dly_t start_target(input dly_t b);
        return (b == '0) ? '0 : b - dly_t'(1);
    endfunction

endpackage

// File: rtl/lstr_dly_hold.sv
module lstr_dly_hold
    import lstr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  dly_set_t live,
    output dly_set_t eff
);
    dly_set_t held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (restart)
            held <= live;
    end

    // the reference edge uses the live values, the rest of the line the held copy
    always_comb eff = restart ? live : held;

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(held));

endmodule

// File: rtl/lstr_line_cnt.sv
module lstr_line_cnt #(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    output logic [DW:0] pos_next,
    output logic        pos_live
);
    localparam logic [DW:0] CAP = (DW+1)'(1) << DW;

    logic [DW:0] pos_q;

    always_comb begin
        if (restart)
            pos_next = '0;
        else if (pos_q == CAP)
            pos_next = CAP;
        else
            pos_next = pos_q + (DW+1)'(1);
        pos_live = !pos_next[DW];
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= CAP;
        else
            pos_q <= pos_next;
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && pos_q != CAP) |=> pos_q == $past(pos_q) + (DW+1)'(1));

endmodule

// File: rtl/lstr_edge_cell.sv
module lstr_edge_cell
    import lstr_pkg::*;
#(
    parameter cell_mode_e MODE = CELL_LEVEL,
    parameter logic       IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_a,
    input  logic hit_b,
    output logic q
);
    generate
        if (MODE == CELL_PULSE) begin : g_pulse
            // hit_b inhibits the pulse
            always_ff @(posedge clk) begin
                if (rst) q <= IDLE;
                else     q <= (hit_a && !hit_b) ? !IDLE : IDLE;
            end
        end else if (MODE == CELL_LEVEL) begin : g_level
            // hit_a drives the active level and wins over hit_b
            always_ff @(posedge clk) begin
                if (rst)        q <= IDLE;
                else if (hit_a) q <= !IDLE;
                else if (hit_b) q <= IDLE;
            end
            // R4
            level_move_chk: assert property (@(posedge clk) disable iff (rst)
                !$stable(q) |-> $past(hit_a || hit_b));
        end else begin : g_toggle
            always_ff @(posedge clk) begin
                if (rst)                   q <= IDLE;
                else if (hit_a && !hit_b)  q <= !q;
            end
            // R6
            tog_cause_chk: assert property (@(posedge clk) disable iff (rst)
                !$stable(q) |-> $past(hit_a));
        end
    endgenerate

endmodule

// File: rtl/lstr_strobe_gen.sv
module lstr_strobe_gen
    import lstr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_start,
    input  logic [LSTR_DW-1:0]   dly_start,
    input  logic [LSTR_DW-1:0]   dly_cls_on,
    input  logic [LSTR_DW-1:0]   dly_cls_off,
    input  logic [LSTR_DW-1:0]   dly_ps_off,
    input  logic [LSTR_DW-1:0]   dly_ps_on,
    input  logic [LSTR_DW-1:0]   dly_rev,
    output logic                 start_pulse,
    output logic                 clk_sel,
    output logic                 pwr_sel,
    output logic                 rev_out
);
    localparam int DW = LSTR_DW;

    dly_set_t    live_d;
    dly_set_t    eff_d;
    logic [DW:0] pos_next;
    logic        pos_live;
    dly_t        pos;
    logic        hit_start, hit_cls_on, hit_cls_off, hit_ps_off, hit_ps_on, hit_rev;

    always_comb begin
        live_d.start   = dly_start;
        live_d.cls_on  = dly_cls_on;
        live_d.cls_off = dly_cls_off;
        live_d.ps_off  = dly_ps_off;
        live_d.ps_on   = dly_ps_on;
        live_d.rev     = dly_rev;
    end

    lstr_dly_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .restart (line_start),
        .live    (live_d),
        .eff     (eff_d)
    );

    lstr_line_cnt #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (line_start),
        .pos_next (pos_next),
        .pos_live (pos_live)
    );

    always_comb begin
        pos         = pos_next[DW-1:0];
        hit_start   = pos_live && (pos == start_target(eff_d.start));
        hit_cls_on  = pos_live && (pos == eff_d.cls_on);
        hit_cls_off = pos_live && (pos == eff_d.cls_off);
        hit_ps_off  = pos_live && (pos == eff_d.ps_off);
        hit_ps_on   = pos_live && (pos == eff_d.ps_on);
        hit_rev     = pos_live && (pos == eff_d.rev);
    end

    lstr_edge_cell #(.MODE(CELL_PULSE), .IDLE(1'b0)) u_start (
        .clk (clk), .rst (rst), .hit_a (hit_start), .hit_b (1'b0), .q (start_pulse)
    );

    lstr_edge_cell #(.MODE(CELL_LEVEL), .IDLE(1'b0)) u_cls (
        .clk (clk), .rst (rst), .hit_a (hit_cls_on), .hit_b (hit_cls_off), .q (clk_sel)
    );

    lstr_edge_cell #(.MODE(CELL_LEVEL), .IDLE(1'b1)) u_ps (
        .clk (clk), .rst (rst), .hit_a (hit_ps_off), .hit_b (hit_ps_on), .q (pwr_sel)
    );

    lstr_edge_cell #(.MODE(CELL_TOGGLE), .IDLE(1'b0)) u_rev (
        .clk (clk), .rst (rst), .hit_a (hit_rev), .hit_b (1'b0), .q (rev_out)
    );

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && !line_start) |=> !start_pulse);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pos_live && !start_pulse) |=> $stable({start_pulse, clk_sel, pwr_sel, rev_out}));

endmodule

// File: tb/sim_lstr_strobe_gen.sv
module sim_lstr_strobe_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic [7:0] d_start = '0, d_con = '0, d_coff = '0, d_poff = '0, d_pon = '0, d_rev = '0;
    logic       start_pulse, clk_sel, pwr_sel, rev_out;

    int    checks = 0;
    int    errors = 0;
    string phase  = "main";

    // bench model state
    int ld[6];
    int age = 0;
    bit started = 0;
    bit e_spl = 0, e_cls = 0, e_ps = 1, e_rev = 0;
    bit c_cls = 0, c_ps = 1, c_rev = 0;

    always #5 clk = ~clk;

    lstr_strobe_gen u0 (
        .clk (clk), .rst (rst), .line_start (line_start),
        .dly_start (d_start), .dly_cls_on (d_con), .dly_cls_off (d_coff),
        .dly_ps_off (d_poff), .dly_ps_on (d_pon), .dly_rev (d_rev),
        .start_pulse (start_pulse), .clk_sel (clk_sel), .pwr_sel (pwr_sel), .rev_out (rev_out)
    );

    function automatic bit f_pulse(int a, int b);
        return a == ((b == 0) ? 0 : b - 1);
    endfunction

    // level with an active edge at on_d and an idle edge at off_d; active wins a tie
    function automatic bit f_level(int a, int on_d, int off_d, bit carry, bit idle);
        bit on_seen  = (on_d <= a);
        bit off_seen = (off_d <= a);
        if (on_seen && off_seen) return (on_d >= off_d) ? !idle : idle;
        if (on_seen)  return !idle;
        if (off_seen) return idle;
        return carry;
    endfunction

    task automatic chk(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
        end
    endtask

    task automatic step(bit ls);
        line_start = ls;
        @(negedge clk);
        if (rst) begin
            started = 0;
            e_spl = 0; e_cls = 0; e_ps = 1; e_rev = 0;
        end else if (ls) begin
            c_cls = e_cls; c_ps = e_ps; c_rev = e_rev;
            ld[0] = d_start; ld[1] = d_con; ld[2] = d_coff;
            ld[3] = d_poff;  ld[4] = d_pon; ld[5] = d_rev;
            age = 0;
            started = 1;
        end else begin
            age++;
        end
        if (started && !rst) begin
            e_spl = f_pulse(age, ld[0]);
            e_cls = f_level(age, ld[1], ld[2], c_cls, 1'b0);
            e_ps  = f_level(age, ld[3], ld[4], c_ps, 1'b1);
            e_rev = c_rev ^ (age >= ld[5]);
            chk("R2", start_pulse, e_spl);
            chk("R3", clk_sel, e_cls);
            chk("R5", pwr_sel, e_ps);
            chk("R6", rev_out, e_rev);
        end else begin
            chk("R1", start_pulse, e_spl);
            chk("R1", clk_sel, e_cls);
            chk("R1", pwr_sel, e_ps);
            chk("R1", rev_out, e_rev);
        end
    endtask

    task automatic set_dly(int a, int b, int c, int d, int e, int f);
        d_start = 8'(a); d_con = 8'(b); d_coff = 8'(c);
        d_poff  = 8'(d); d_pon = 8'(e); d_rev  = 8'(f);
    endtask

    task automatic rand_dly();
        set_dly($urandom_range(0, 99), $urandom_range(0, 99), $urandom_range(0, 99),
                $urandom_range(0, 99), $urandom_range(0, 99), $urandom_range(0, 99));
    endtask

    task automatic run_line(int len);
        step(1'b1);
        for (int i = 1; i < len; i++) step(1'b0);
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset values, then no movement before a line starts even with zero delays
        phase = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b0);

        // R2: start delay 0 and 1 both fire on the reference edge, then a later one
        phase = "R2";
        set_dly(0, 2, 4, 3, 5, 1);
        run_line(6);
        set_dly(1, 0, 0, 0, 0, 0);
        run_line(6);
        set_dly(7, 3, 9, 2, 6, 4);
        run_line(12);

        // R4 and R5: equal on/off delays
        phase = "R4";
        set_dly(3, 4, 4, 7, 7, 2);
        run_line(12);

        // R7: change delays mid-line, the line keeps the sampled set
        phase = "R7";
        set_dly(10, 12, 20, 14, 22, 16);
        step(1'b1);
        for (int i = 1; i < 5; i++) step(1'b0);
        set_dly(2, 3, 4, 5, 6, 7);
        for (int i = 5; i < 30; i++) step(1'b0);
        run_line(12);

        // R8: back-to-back starts, then a line cut before its edges
        phase = "R8";
        set_dly(0, 0, 1, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1'b1);
        set_dly(50, 40, 45, 42, 48, 44);
        run_line(10);
        set_dly(2, 3, 6, 4, 8, 5);
        run_line(300);

        // random lines, some with mid-line delay writes
        phase = "random";
        for (int n = 0; n < 80; n++) begin
            int len = $urandom_range(1, 90);
            int chg = ($urandom_range(0, 9) < 3) ? $urandom_range(1, 90) : 0;
            rand_dly();
            step(1'b1);
            for (int i = 1; i < len; i++) begin
                if (i == chg) rand_dly();
                step(1'b0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule